// File: doc/BRIEF.md
# AXI Read Downsizing Bridge to a 32-bit AHB Slave

This block is the read half of a bridge between a 64-bit AXI4 master and a 32-bit AHB-Lite slave. It takes one read request at a time on the AR channel and breaks each 64-bit beat into a pair of word reads on the AHB side. The first read is at the beat address and the second is four bytes higher. The two returned words are joined into a single 64-bit R beat, with the lower address in the low half. The upper half always carries real slave data and is never zero-filled.

The block accepts both FIXED and INCR bursts of 8-byte beats, and the start address must be 8-byte aligned. AHB has no burst type that re-reads the same addresses. For a FIXED burst, every beat therefore re-issues the same incrementing word pair. For an INCR burst, each new pair starts 8 bytes after the previous one. The bridge starts the next pair only after the master has taken the current beat, so it never needs more than one beat of storage.

Top module: `axi_ahb_rd_downsizer`

## Requirements
- R1: `ar_ready` is high exactly when no burst is in progress. The `ar_id` captured on acceptance is returned on `r_id` for every beat of that burst.
- R2: Each beat makes two AHB word reads: first at address A with `htrans` = NONSEQ (2'b10), then at A+4 with `htrans` = SEQ (2'b11). Both use `hburst` = INCR (3'b001) and `hsize` = word (3'b010). Every AHB address is word aligned.
- R3: With `ar_burst` = FIXED (2'b00), every beat uses the start address as A. With `ar_burst` = INCR (2'b01), A advances by 8 on each beat.
- R4: `r_data[31:0]` holds the word read at A and `r_data[63:32]` holds the word read at A+4.
- R5: A burst returns `ar_len`+1 beats and issues exactly twice that many AHB reads. `r_last` is high on the final beat only.
- R6: While `hready` is low, the pending AHB address phase holds `haddr` and `htrans` steady. Data is captured only on cycles where `hready` is high.
- R7: If either word of a pair returns `hresp` = ERROR (1), that beat carries `r_resp` = SLVERR (2'b10); otherwise it carries OKAY (2'b00). The remaining beats of the burst are still read.
- R8: Once `r_valid` rises, it stays high with `r_data`, `r_resp`, `r_last` and `r_id` unchanged until `r_ready` is seen. During that wait `htrans` stays IDLE.
- R9: `hwrite` is always 0. `htrans` is IDLE (2'b00) after reset and between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ar_valid | input | 1 | Read request valid |
| ar_ready | output | 1 | Read request accepted (bridge idle) |
| ar_addr | input | ADDR_W | Burst start address, 8-byte aligned |
| ar_id | input | ID_W | Transaction tag |
| ar_len | input | LEN_W | Beats minus one |
| ar_burst | input | 2 | 00 FIXED, 01 INCR |
| r_valid | output | 1 | Read beat valid |
| r_ready | input | 1 | Read beat taken |
| r_data | output | 2*WORD_W | Assembled beat |
| r_id | output | ID_W | Tag of the current burst |
| r_resp | output | 2 | 00 OKAY, 10 SLVERR |
| r_last | output | 1 | Final beat marker |
| haddr | output | ADDR_W | AHB address |
| htrans | output | 2 | AHB transfer kind |
| hburst | output | 3 | AHB burst kind |
| hsize | output | 3 | AHB transfer size |
| hwrite | output | 1 | AHB direction (always read) |
| hrdata | input | WORD_W | AHB read data |
| hready | input | 1 | AHB transfer done |
| hresp | input | 1 | AHB error response |

## Verification
The bench sweeps both burst kinds over every length from one to four beats and over zero, one and two slave wait states. Each beat is held back by zero to two cycles on `r_ready`. The FIXED runs separate re-reading of one address pair from advancing it, and the wait-state runs separate correct capture timing from capture on stalled cycles. The slave returns an address-derived word for every read, so a swapped half, a zero-filled upper half or a wrong address shows up as a data mismatch. Three error bursts place a slave error on the low word, on the high word, and on a beat of a FIXED burst that repeats on every beat, which separates per-beat error marking from sticky or dropped errors.

// File: rtl/axi_ahb_rd_pkg.sv
package axi_ahb_rd_pkg;
  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ    = 2'b11;
  localparam logic [2:0] HB_SINGLE = 3'b000;
  localparam logic [2:0] HB_INCR   = 3'b001;
  localparam logic [2:0] HS_WORD   = 3'b010;
  localparam logic [1:0] AXB_FIXED = 2'b00;
  localparam logic [1:0] AXB_INCR  = 2'b01;
  localparam logic [1:0] RSP_OKAY  = 2'b00;
  localparam logic [1:0] RSP_SLV   = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_LO,
    ST_ADDR_HI,
    ST_DATA_HI,
    ST_HOLD
  } pair_state_t;
endpackage

// File: rtl/axi_ahb_rd_addr_gen.sv
module axi_ahb_rd_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              fixed,
  output logic [ADDR_W-1:0] next_base,
  output logic              last_beat
);
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic              fixed_q;

  assign next_base = fixed_q ? base_q : base_q + ADDR_W'(BEAT_BYTES);
  assign last_beat = (cnt_q == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      fixed_q <= 1'b0;
    end else if (load) begin
      base_q  <= start_addr;
      cnt_q   <= '0;
      len_q   <= len;
      fixed_q <= fixed;
    end else if (advance) begin
      base_q  <= next_base;
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/axi_ahb_rd_pair_ctrl.sv
module axi_ahb_rd_pair_ctrl
  import axi_ahb_rd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] next_base,
  input  logic              last_beat,
  input  logic              beat_taken,
  input  logic              hready,
  output logic              busy,
  output logic              advance,
  output logic              cap_lo,
  output logic              cap_hi,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic [2:0]        hburst
);
  pair_state_t st_q;
  logic [ADDR_W-1:0] haddr_q;
  logic [1:0]        htrans_q;
  logic [2:0]        hburst_q;

  assign busy    = (st_q != ST_IDLE);
  assign cap_lo  = (st_q == ST_ADDR_HI) && hready;
  assign cap_hi  = (st_q == ST_DATA_HI) && hready;
  assign advance = (st_q == ST_HOLD) && beat_taken && !last_beat;
  assign haddr   = haddr_q;
  assign htrans  = htrans_q;
  assign hburst  = hburst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      haddr_q  <= '0;
      htrans_q <= HT_IDLE;
      hburst_q <= HB_SINGLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q     <= ST_ADDR_LO;
          haddr_q  <= start_addr;
          htrans_q <= HT_NONSEQ;
          hburst_q <= HB_INCR;
        end
        ST_ADDR_LO: if (hready) begin
          st_q     <= ST_ADDR_HI;
          haddr_q  <= haddr_q + ADDR_W'(WORD_BYTES);
          htrans_q <= HT_SEQ;
        end
        ST_ADDR_HI: if (hready) begin
          st_q     <= ST_DATA_HI;
          htrans_q <= HT_IDLE;
          hburst_q <= HB_SINGLE;
        end
        ST_DATA_HI: if (hready) st_q <= ST_HOLD;
        ST_HOLD: if (beat_taken) begin
          if (last_beat) begin
            st_q <= ST_IDLE;
          end else begin
            st_q     <= ST_ADDR_LO;
            haddr_q  <= next_base;
            htrans_q <= HT_NONSEQ;
            hburst_q <= HB_INCR;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axi_ahb_rd_beat_pack.sv
module axi_ahb_rd_beat_pack
  import axi_ahb_rd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_lo,
  input  logic                cap_hi,
  input  logic                last_beat,
  input  logic [WORD_W-1:0]   hrdata,
  input  logic                hresp,
  input  logic                r_ready,
  output logic                r_valid,
  output logic [2*WORD_W-1:0] r_data,
  output logic [1:0]          r_resp,
  output logic                r_last,
  output logic                beat_taken
);
  logic [WORD_W-1:0] lo_q;
  logic              err_lo_q;

  assign beat_taken = r_valid && r_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q     <= '0;
      err_lo_q <= 1'b0;
      r_valid  <= 1'b0;
      r_data   <= '0;
      r_resp   <= RSP_OKAY;
      r_last   <= 1'b0;
    end else begin
      if (cap_lo) begin
        lo_q     <= hrdata;
        err_lo_q <= hresp;
      end
      if (cap_hi) begin
        r_valid  <= 1'b1;
        r_data   <= {hrdata, lo_q};
        r_resp   <= (err_lo_q || hresp) ? RSP_SLV : RSP_OKAY;
        r_last   <= last_beat;
        err_lo_q <= 1'b0;
      end else if (beat_taken) begin
        r_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/axi_ahb_rd_downsizer.sv
module axi_ahb_rd_downsizer
  import axi_ahb_rd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ar_valid,
  output logic                ar_ready,
  input  logic [ADDR_W-1:0]   ar_addr,
  input  logic [ID_W-1:0]     ar_id,
  input  logic [LEN_W-1:0]    ar_len,
  input  logic [1:0]          ar_burst,
  output logic                r_valid,
  input  logic                r_ready,
  output logic [2*WORD_W-1:0] r_data,
  output logic [ID_W-1:0]     r_id,
  output logic [1:0]          r_resp,
  output logic                r_last,
  output logic [ADDR_W-1:0]   haddr,
  output logic [1:0]          htrans,
  output logic [2:0]          hburst,
  output logic [2:0]          hsize,
  output logic                hwrite,
  input  logic [WORD_W-1:0]   hrdata,
  input  logic                hready,
  input  logic                hresp
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int BEAT_BYTES = 2 * WORD_BYTES;

  logic              busy, start, advance, cap_lo, cap_hi, beat_taken, last_beat;
  logic [ADDR_W-1:0] next_base;
  logic [ID_W-1:0]   id_q;

  assign ar_ready = !busy;
  assign start    = ar_valid && !busy;
  assign r_id     = id_q;
  assign hsize    = HS_WORD;
  assign hwrite   = 1'b0;

  always_ff @(posedge clk) begin
    if (rst)        id_q <= '0;
    else if (start) id_q <= ar_id;
  end

  axi_ahb_rd_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_addr (
    .clk, .rst, .load(start), .advance, .start_addr(ar_addr), .len(ar_len),
    .fixed(ar_burst == AXB_FIXED), .next_base, .last_beat
  );

  axi_ahb_rd_pair_ctrl #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_ctrl (
    .clk, .rst, .start, .start_addr(ar_addr), .next_base, .last_beat, .beat_taken,
    .hready, .busy, .advance, .cap_lo, .cap_hi, .haddr, .htrans, .hburst
  );

  axi_ahb_rd_beat_pack #(.WORD_W(WORD_W)) u_pack (
    .clk, .rst, .cap_lo, .cap_hi, .last_beat, .hrdata, .hresp, .r_ready,
    .r_valid, .r_data, .r_resp, .r_last, .beat_taken
  );
endmodule

// File: rtl/axi_ahb_rd_downsizer_chk.sv
module axi_ahb_rd_downsizer_chk
  import axi_ahb_rd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                ar_ready,
  input logic                r_valid,
  input logic                r_ready,
  input logic [2*WORD_W-1:0] r_data,
  input logic [ID_W-1:0]     r_id,
  input logic [1:0]          r_resp,
  input logic                r_last,
  input logic [ADDR_W-1:0]   haddr,
  input logic [1:0]          htrans,
  input logic [2:0]          hburst,
  input logic [2:0]          hsize,
  input logic                hwrite,
  input logic                hready
);
  a_r1_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
    ar_ready |-> (!r_valid && htrans == HT_IDLE));

  a_r2_seq_follows: assert property (@(posedge clk) disable iff (rst)
    (htrans == HT_NONSEQ && hready) |=> (htrans == HT_SEQ && haddr == $past(haddr) + ADDR_W'(WORD_W / 8)));

  a_r2_word_incr: assert property (@(posedge clk) disable iff (rst)
    (htrans != HT_IDLE) |-> (hsize == HS_WORD && hburst == HB_INCR && haddr[1:0] == 2'b00));

  a_r5_idle_after_last: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_ready && r_last) |=> ar_ready);

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (htrans != HT_IDLE && !hready) |=> ($stable(haddr) && $stable(htrans)));

  a_r7_resp_code: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> (r_resp == RSP_OKAY || r_resp == RSP_SLV));

  a_r8_beat_hold: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_resp) && $stable(r_last) && $stable(r_id)));

  a_r8_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> (htrans == HT_IDLE));

  a_r9_read_only: assert property (@(posedge clk) disable iff (rst)
    !hwrite);
endmodule

bind axi_ahb_rd_downsizer axi_ahb_rd_downsizer_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .ar_ready(ar_ready), .r_valid(r_valid), .r_ready(r_ready),
  .r_data(r_data), .r_id(r_id), .r_resp(r_resp), .r_last(r_last), .haddr(haddr),
  .htrans(htrans), .hburst(hburst), .hsize(hsize), .hwrite(hwrite), .hready(hready)
);

// File: tb/axi_ahb_rd_downsizer_bench.sv
module axi_ahb_rd_downsizer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int LW = 8;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ar_valid = 1'b0, ar_ready;
  logic [AW-1:0] ar_addr = '0;
  logic [IW-1:0] ar_id = '0;
  logic [LW-1:0] ar_len = '0;
  logic [1:0] ar_burst = '0;
  logic r_valid, r_ready = 1'b0, r_last;
  logic [2*WW-1:0] r_data;
  logic [IW-1:0] r_id;
  logic [1:0] r_resp;
  logic [AW-1:0] haddr;
  logic [1:0] htrans;
  logic [2:0] hburst, hsize;
  logic hwrite;
  logic [WW-1:0] hrdata;
  logic hready, hresp;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_ahb_rd_downsizer u_axi_ahb_rd_downsizer (
    .clk, .rst, .ar_valid, .ar_ready, .ar_addr, .ar_id, .ar_len, .ar_burst,
    .r_valid, .r_ready, .r_data, .r_id, .r_resp, .r_last,
    .haddr, .htrans, .hburst, .hsize, .hwrite, .hrdata, .hready, .hresp
  );

  function automatic logic [WW-1:0] word_at(input logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // slave model
  int            waits_cfg = 0;
  logic [AW-1:0] err_addr = 32'hFFFF_FFF0;
  logic          dp_valid = 1'b0, err2 = 1'b0;
  logic [AW-1:0] dp_addr = '0;
  int            wait_cnt = 0;
  logic          is_err;
  logic [AW-1:0] log_addr [1024];
  logic [1:0]    log_trans [1024];
  logic [2:0]    log_burst [1024];
  logic [2:0]    log_size [1024];
  logic          log_write [1024];
  int            n_log = 0;
  int            stall_bad = 0;
  logic          prev_stall = 1'b0;
  logic [AW-1:0] stall_addr = '0;
  logic [1:0]    stall_trans = '0;

  always_comb begin
    is_err = dp_valid && (dp_addr == err_addr);
    hrdata = word_at(dp_addr);
    hresp  = is_err && (wait_cnt == 0);
    if (!dp_valid)          hready = 1'b1;
    else if (wait_cnt != 0) hready = 1'b0;
    else if (is_err)        hready = err2;
    else                    hready = 1'b1;
  end

  always @(posedge clk) begin
    if (rst) begin
      dp_valid <= 1'b0; err2 <= 1'b0; wait_cnt <= 0; prev_stall <= 1'b0;
    end else begin
      if (prev_stall && (haddr != stall_addr || htrans != stall_trans)) stall_bad <= stall_bad + 1;
      prev_stall  <= htrans[1] && !hready;
      stall_addr  <= haddr;
      stall_trans <= htrans;
      if (hready) begin
        dp_valid <= htrans[1];
        dp_addr  <= haddr;
        wait_cnt <= waits_cfg;
        err2     <= 1'b0;
        if (htrans[1] && n_log < 1024) begin
          log_addr[n_log]  <= haddr;
          log_trans[n_log] <= htrans;
          log_burst[n_log] <= hburst;
          log_size[n_log]  <= hsize;
          log_write[n_log] <= hwrite;
          n_log <= n_log + 1;
        end
      end else if (wait_cnt != 0) begin
        wait_cnt <= wait_cnt - 1;
      end else if (is_err) begin
        err2 <= 1'b1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_burst(input logic [AW-1:0] a, input int len, input bit fixed,
                           input logic [IW-1:0] id, input int waits, input int rdly,
                           input logic [AW-1:0] eaddr);
    int log0, n_pairs;
    bit addr_ok, kind_ok, wr_ok;
    logic [AW-1:0] base;
    logic [2*WW-1:0] snap;
    bit hold_ok;
    waits_cfg = waits;
    err_addr  = eaddr;
    log0      = n_log;
    while (!ar_ready) @(negedge clk);
    ar_valid = 1'b1; ar_addr = a; ar_id = id; ar_len = LW'(len);
    ar_burst = fixed ? 2'b00 : 2'b01;
    @(negedge clk);
    ar_valid = 1'b0;
    chk(!ar_ready, "R1", "ar_ready low while busy", 64'(ar_ready), 64'd0);
    for (int b = 0; b <= len; b++) begin
      base = fixed ? a : a + AW'(8 * b);
      while (!r_valid) @(negedge clk);
      snap = r_data;
      hold_ok = 1'b1;
      for (int d = 0; d < rdly; d++) begin
        @(negedge clk);
        if (!r_valid || r_data != snap || htrans != 2'b00) hold_ok = 1'b0;
      end
      if (rdly > 0) chk(hold_ok, "R8", "beat held while not ready", 64'(hold_ok), 64'd1);
      chk(r_data == {word_at(base + 4), word_at(base)}, "R4", "beat data",
          r_data, {word_at(base + 4), word_at(base)});
      chk(r_resp == ((eaddr == base || eaddr == base + 4) ? 2'b10 : 2'b00), "R7", "beat resp",
          64'(r_resp), 64'((eaddr == base || eaddr == base + 4) ? 2'b10 : 2'b00));
      chk(r_id == id, "R1", "beat id", 64'(r_id), 64'(id));
      chk(r_last == (b == len), "R5", "last flag", 64'(r_last), 64'(b == len));
      r_ready = 1'b1;
      @(negedge clk);
      r_ready = 1'b0;
    end
    @(negedge clk);
    n_pairs = (n_log - log0) / 2;
    chk(n_log - log0 == 2 * (len + 1), "R5", "AHB read count", 64'(n_log - log0), 64'(2 * (len + 1)));
    addr_ok = 1'b1; kind_ok = 1'b1; wr_ok = 1'b1;
    for (int p = 0; p < n_pairs && p <= len; p++) begin
      base = fixed ? a : a + AW'(8 * p);
      if (log_addr[log0 + 2*p] != base || log_addr[log0 + 2*p + 1] != base + 4) addr_ok = 1'b0;
      if (log_trans[log0 + 2*p] != 2'b10 || log_trans[log0 + 2*p + 1] != 2'b11) kind_ok = 1'b0;
      for (int k = 0; k < 2; k++) begin
        if (log_burst[log0 + 2*p + k] != 3'b001 || log_size[log0 + 2*p + k] != 3'b010) kind_ok = 1'b0;
        if (log_write[log0 + 2*p + k] != 1'b0) wr_ok = 1'b0;
      end
    end
    chk(addr_ok, "R3", "pair addresses per beat", 64'(addr_ok), 64'd1);
    chk(kind_ok, "R2", "NONSEQ/SEQ word INCR pairs", 64'(kind_ok), 64'd1);
    chk(wr_ok, "R9", "hwrite low on every read", 64'(wr_ok), 64'd1);
    chk(stall_bad == 0, "R6", "address held under wait", 64'(stall_bad), 64'd0);
    chk(ar_ready && htrans == 2'b00, "R9", "idle bus between bursts", {62'd0, htrans}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ar_ready == 1'b1, "R1", "ar_ready after reset", 64'(ar_ready), 64'd1);
    chk(r_valid == 1'b0, "R8", "r_valid after reset", 64'(r_valid), 64'd0);
    chk(htrans == 2'b00, "R9", "htrans after reset", 64'(htrans), 64'd0);
    chk(hwrite == 1'b0, "R9", "hwrite after reset", 64'(hwrite), 64'd0);
    for (int bt = 0; bt < 2; bt++)
      for (int ln = 0; ln < 4; ln++)
        for (int w = 0; w < 3; w++) begin
          int idx = bt * 12 + ln * 3 + w;
          run_burst(32'h100 + AW'(idx * 64), ln, bt == 0, IW'(idx), w, idx % 3, 32'hFFFF_FFF0);
        end
    // R7: error on high word of a FIXED burst repeats every beat
    run_burst(32'h800, 2, 1'b1, 4'hA, 1, 1, 32'h804);
    // R7: error on low word of beat 1 of an INCR burst only
    run_burst(32'h900, 3, 1'b0, 4'hB, 0, 0, 32'h908);
    // R7: error on high word of beat 2, with waits
    run_burst(32'hA00, 3, 1'b0, 4'hC, 2, 2, 32'hA14);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule